// File: doc/BRIEF.md
# Shared-Bus Latched Channel Control Port

This block models the digital control side of four line-interface channels that hang off one shared set of control and status wires. A controller drives a single 2-bit state-select word and a single 3-bit relay-driver word onto the shared bus. Each channel has its own hold line. While a channel's hold line is low, that channel's internal latch is open and takes the bus word. While its hold line is high, the channel keeps the last word it took and ignores the bus.

On the return path each channel has two detectors: loop (off-hook) and thermal shutdown. A channel pulls a shared active-low status wire low only while its hold line is low and the matching detector fires. Otherwise it leaves the wire to an implied pull-up, which reads high. The shared wires are resolved as a wired-AND of all channels. A conflict flag rises when two or more open channels would drive the shared status wires at the same time.

The transparent latch is modelled as a clocked register that loads on every clock edge while its hold line is low. The exposed state therefore trails the bus by one cycle.

Top module: `ctrl_bus_quad`

## Requirements
- R1: While reset is asserted and after it, every channel's state field reads 00 and every driver field reads 000, whatever is on the bus.
- R2: When a channel's hold line is low at a rising clock edge, its state field (`ch_state[2i+1:2i]` = {select bit 1, select bit 0}) and driver field (`ch_drive[3i+2:3i]`, bit k = relay driver k) equal the bus values sampled at that edge, visible one cycle later.
- R3: When a channel's hold line is high at a rising clock edge, its state and driver fields keep their previous values, whatever changes on the bus.
- R4: `loop_n` is 0 exactly when at least one channel has its hold line low and its loop detector high; otherwise it is 1. This is combinational, with no clock delay.
- R5: `therm_n` is 0 exactly when at least one channel has its hold line low and its thermal detector high; otherwise it is 1. This is combinational.
- R6: With every hold line high, `loop_n` and `therm_n` both read 1, whatever the detectors show.
- R7: `bus_conflict` is 1 exactly when two or more channels have their hold line low and at least one detector high each.
- R8: A relay word of 000 taken by an open channel leaves all three of that channel's driver outputs at 0 (inactive, 1 = active) from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Shared state-select word |
| bus_relay | input | 3 | Shared relay-driver word |
| ch_hold | input | 4 | Per-channel hold line; 0 = latch open, 1 = hold |
| det_loop | input | 4 | Per-channel loop (off-hook) detector |
| det_therm | input | 4 | Per-channel thermal-shutdown detector |
| ch_state | output | 8 | Latched state-select fields, 2 bits per channel |
| ch_drive | output | 12 | Latched relay-driver outputs, 3 bits per channel |
| loop_n | output | 1 | Shared active-low loop status, wired-AND |
| therm_n | output | 1 | Shared active-low thermal status, wired-AND |
| bus_conflict | output | 1 | Two or more open channels driving status |

## Verification
The bench first walks the hold lines one channel at a time with a distinct bus word per channel. Each channel then holds a different value, so a channel that loaded a word meant for another, or lost its own, shows up at once. It then changes the bus while every channel is held, and applies detector patterns with zero, one and several open channels. These patterns separate correct gating of the status wires from ignoring the hold line, from an OR instead of an AND on the shared wire, and from a conflict flag that counts one driver as two. A long run of pseudo-random hold, bus and detector values follows, compared cycle by cycle against a behavioural model.

// File: rtl/ctrl_bus_pkg.sv
package ctrl_bus_pkg;

  localparam int SEL_W = 2;
  localparam int RLY_W = 3;

  typedef struct packed {
    logic [RLY_W-1:0] relay;
    logic [SEL_W-1:0] sel;
  } ctl_word_t;

  // Open-drain pull: a channel pulls its status wire low only while open and detecting.
  function automatic logic pulls_low(input logic hold, input logic det);
    return (!hold) && det;
  endfunction

  // A channel is driving the shared status bus when either wire is pulled.
  function automatic logic is_driving(input logic hold, input logic dl, input logic dt);
    return pulls_low(hold, dl) || pulls_low(hold, dt);
  endfunction

endpackage

// File: rtl/ctrl_chan.sv
module ctrl_chan
  import ctrl_bus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [RLY_W-1:0] bus_relay,
  input  logic             det_loop,
  input  logic             det_therm,
  output logic [SEL_W-1:0] state_q,
  output logic [RLY_W-1:0] drive_q,
  output logic             loop_pull_n,
  output logic             therm_pull_n,
  output logic             driving
);

  ctl_word_t word_q;
  ctl_word_t word_d;
  logic      load_ev;

  assign load_ev = !hold;

  always_comb begin
    word_d.sel   = bus_sel;
    word_d.relay = bus_relay;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_ev) begin
      word_q <= word_d;
    end
  end

  assign state_q      = word_q.sel;
  assign drive_q      = word_q.relay;
  assign loop_pull_n  = !pulls_low(hold, det_loop);
  assign therm_pull_n = !pulls_low(hold, det_therm);
  assign driving      = is_driving(hold, det_loop, det_therm);

  // R1: reset leaves the latch cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (state_q == '0 && drive_q == '0) || rst_n);

  // R2: open latch takes the bus word
  assert_open_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold) |=> (state_q == $past(bus_sel) && drive_q == $past(bus_relay)));

  // R3: held latch ignores the bus
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && hold) |=> ($stable(state_q) && $stable(drive_q)));

  // R8: zero relay word leaves drivers inactive
  assert_relay_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold && bus_relay == '0) |=> (drive_q == '0));

endmodule

// File: rtl/status_merge.sv
module status_merge #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] loop_pull_n,
  input  logic [NUM_CH-1:0] therm_pull_n,
  input  logic [NUM_CH-1:0] driving,
  output logic              loop_n,
  output logic              therm_n,
  output logic              conflict
);

  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  // Wired-AND: any channel pulling low wins, pull-up otherwise.
  assign loop_n  = &loop_pull_n;
  assign therm_n = &therm_pull_n;

  // More than one bit set: clearing the lowest set bit leaves something.
  assign conflict = |(driving & (driving - ONE));

endmodule

// File: rtl/ctrl_bus_quad.sv
module ctrl_bus_quad
  import ctrl_bus_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEL_W-1:0]        bus_sel,
  input  logic [RLY_W-1:0]        bus_relay,
  input  logic [NUM_CH-1:0]       ch_hold,
  input  logic [NUM_CH-1:0]       det_loop,
  input  logic [NUM_CH-1:0]       det_therm,
  output logic [NUM_CH*SEL_W-1:0] ch_state,
  output logic [NUM_CH*RLY_W-1:0] ch_drive,
  output logic                    loop_n,
  output logic                    therm_n,
  output logic                    bus_conflict
);

  logic [NUM_CH-1:0] loop_pull_n;
  logic [NUM_CH-1:0] therm_pull_n;
  logic [NUM_CH-1:0] driving;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ctrl_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .hold         (ch_hold[i]),
      .bus_sel      (bus_sel),
      .bus_relay    (bus_relay),
      .det_loop     (det_loop[i]),
      .det_therm    (det_therm[i]),
      .state_q      (ch_state[i*SEL_W +: SEL_W]),
      .drive_q      (ch_drive[i*RLY_W +: RLY_W]),
      .loop_pull_n  (loop_pull_n[i]),
      .therm_pull_n (therm_pull_n[i]),
      .driving      (driving[i])
    );
  end

  status_merge #(.NUM_CH(NUM_CH)) u_merge (
    .loop_pull_n  (loop_pull_n),
    .therm_pull_n (therm_pull_n),
    .driving      (driving),
    .loop_n       (loop_n),
    .therm_n      (therm_n),
    .conflict     (bus_conflict)
  );

  // Port-level views for the checks below.
  logic [NUM_CH-1:0] open_loop;
  logic [NUM_CH-1:0] open_therm;
  assign open_loop  = ~ch_hold & det_loop;
  assign open_therm = ~ch_hold & det_therm;

  // R4: shared loop wire low exactly when an open channel detects
  assert_loop_wire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_n == 1'b0) == (open_loop != '0));

  // R5: shared thermal wire low exactly when an open channel detects
  assert_therm_wire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_n == 1'b0) == (open_therm != '0));

  // R6: nobody open, both wires float high
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&ch_hold) |-> (loop_n && therm_n));

  // R7: conflict flag matches two or more driving open channels
  assert_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_conflict == ($countones(open_loop | open_therm) >= 2));

endmodule

// File: tb/ctrl_bus_quad_tb_top.sv
`timescale 1ns/100ps
module ctrl_bus_quad_tb_top;

  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     bus_sel = '0;
  logic [2:0]     bus_relay = '0;
  logic [N-1:0]   ch_hold = '1;
  logic [N-1:0]   det_loop = '0;
  logic [N-1:0]   det_therm = '0;
  logic [2*N-1:0] ch_state;
  logic [3*N-1:0] ch_drive;
  logic           loop_n, therm_n, bus_conflict;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Behavioural reference: per-channel latched values as integers.
  int ref_sel[N];
  int ref_rly[N];
  bit in_reset = 1;

  always #2.5 clk = ~clk;

  ctrl_bus_quad dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_relay(bus_relay),
    .ch_hold(ch_hold), .det_loop(det_loop), .det_therm(det_therm),
    .ch_state(ch_state), .ch_drive(ch_drive), .loop_n(loop_n),
    .therm_n(therm_n), .bus_conflict(bus_conflict)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output with the model; tags reflect the situation.
  task automatic compare_all(input bit [N-1:0] held_prev);
    int exp_loop, exp_therm, ndrv;
    exp_loop = 1; exp_therm = 1; ndrv = 0;
    for (int i = 0; i < N; i++) begin
      string tag_s, tag_d;
      tag_s = in_reset ? "R1" : (held_prev[i] ? "R3" : "R2");
      tag_d = (!in_reset && ref_rly[i] == 0) ? "R8" : tag_s;
      chk(tag_s, int'(ch_state[2*i +: 2]), ref_sel[i]);
      chk(tag_d, int'(ch_drive[3*i +: 3]), ref_rly[i]);
      if (ch_hold[i] == 1'b0) begin
        if (det_loop[i]) exp_loop = 0;
        if (det_therm[i]) exp_therm = 0;
        if (det_loop[i] || det_therm[i]) ndrv++;
      end
    end
    if (!in_reset) begin
      if (&ch_hold) begin
        chk("R6", int'(loop_n), 1);
        chk("R6", int'(therm_n), 1);
      end else begin
        chk("R4", int'(loop_n), exp_loop);
        chk("R5", int'(therm_n), exp_therm);
      end
      chk("R7", int'(bus_conflict), (ndrv >= 2) ? 1 : 0);
    end
  endtask

  bit [N-1:0] last_hold = '1;

  // One cycle: drive at negedge, compare, then let the edge update the model.
  task automatic step(input bit [N-1:0] h, input int s, input int r,
                      input bit [N-1:0] dl, input bit [N-1:0] dt);
    @(negedge clk);
    ch_hold = h; bus_sel = 2'(s); bus_relay = 3'(r);
    det_loop = dl; det_therm = dt;
    #1;
    compare_all(last_hold);
    @(posedge clk);
    #0.1;
    if (rst_n) begin
      in_reset = 0;
      for (int i = 0; i < N; i++)
        if (!h[i]) begin ref_sel[i] = s; ref_rly[i] = r; end
    end
    last_hold = h;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin ref_sel[i] = 0; ref_rly[i] = 0; end
    // R1: open all channels with a nonzero bus word during reset
    step(4'b0000, 3, 7, 4'b0000, 4'b0000);
    step(4'b0000, 2, 5, 4'b0000, 4'b0000);
    rst_n = 1'b1;
    step(4'b1111, 1, 1, 4'b0000, 4'b0000);
    // R2: walk channels one at a time with distinct words
    for (int c = 0; c < N; c++) step(~(4'b0001 << c), c, 7 - c, 4'b0000, 4'b0000);
    // R3: bus moves while every channel holds
    step(4'b1111, 3, 0, 4'b0000, 4'b0000);
    step(4'b1111, 0, 6, 4'b0000, 4'b0000);
    step(4'b1111, 2, 3, 4'b0000, 4'b0000);
    // R6: detectors on, nobody open
    step(4'b1111, 0, 0, 4'b1111, 4'b1111);
    // R4/R5: single open channel, each detector alone
    step(4'b1110, 1, 2, 4'b0001, 4'b0000);
    step(4'b1101, 1, 2, 4'b0000, 4'b0010);
    step(4'b1011, 1, 2, 4'b1011, 4'b1011);
    // R7: two open channels driving, then one driving and one quiet
    step(4'b0011, 2, 4, 4'b1100, 4'b0000);
    step(4'b0011, 2, 4, 4'b0100, 4'b0000);
    step(4'b0110, 2, 4, 4'b0010, 4'b1000);
    step(4'b0000, 3, 1, 4'b0001, 4'b1000);
    // R8: zero relay word to every channel
    step(4'b0000, 0, 0, 4'b0000, 4'b0000);
    step(4'b1111, 3, 7, 4'b0000, 4'b0000);
    // Pseudo-random run
    begin
      bit [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        step(lfsr[3:0] | lfsr[7:4], int'(lfsr[9:8]), int'(lfsr[12:10]),
             lfsr[16:13], lfsr[20:17]);
      end
    end
    step(4'b1111, 0, 0, 4'b0000, 4'b0000);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule